// File: doc/BRIEF.md
# OSD Shadow and Background Mixer

This block is the last pixel stage of an on-screen display. For each pixel it takes a glyph bit from the raster generator and the attributes of the character that pixel belongs to. It returns a 3-bit colour code and a flag that tells the video switch to replace the picture with OSD colour. The block handles three pixel kinds:

- **Glyph pixels** take the character's foreground colour.
- **Shadow pixels** take a fixed shadow colour (parameter `SHADOW_CLR`). The shadow shape depends on a sub-mode latched once per line.
- **Background pixels** take the character's background colour. Where background is drawn depends on a primary mode latched once per frame: TV mode or frame mode.

Characters marked as blinking disappear for half of a blink period. The period is the count of vertical sync pulses divided by 32 or 64, chosen per character.

A small raster state machine follows the sync pulses and decides when pixels are accepted. It has three states:

- `ST_NOFRAME`: the state after reset. It moves to `ST_VGAP` on the first vertical sync.
- `ST_VGAP`: the gap after a vertical sync. A further vertical sync keeps it in `ST_VGAP`. A line sync moves it to `ST_LINE`.
- `ST_LINE`: pixels are being accepted. A line sync stays in `ST_LINE` and starts a new line. A vertical sync returns it to `ST_VGAP`.

Shadows look at neighbouring pixels, so the block keeps the visible glyph bits of the current line and of the previous line. It uses only pixels that have already arrived. This keeps the latency at one clock.

Top module: `osd_shade_mixer`

## Requirements
- R1: While reset is asserted, and after it is released, `osd_color` is 0 and `osd_active` is 0.
- R2: A pixel is accepted only when all of the following hold:
  - `pix_de` is high.
  - No sync pulse is present in that cycle.
  - At least one line sync has been seen since the last vertical sync, and a vertical sync has been seen since reset.

  Every accepted pixel produces its result on the outputs exactly one clock later. In every other cycle, the outputs one clock later are colour 0 and inactive.
- R3: An accepted pixel that is inside a cell (`pix_cell`=1) and has `pix_glyph`=1, and is not blinked off, outputs `pix_fg` and is active.
- R4: Sub-mode code 0 (overlay) in TV mode: a non-glyph pixel inside a cell outputs colour 0 and inactive.
- R5: Sub-mode code 2 (panel): a non-glyph pixel inside a cell outputs `pix_bg` and is active. Sub-modes 1 and 3 also fill a cell pixel with `pix_bg` when it is neither a glyph nor a shadow.
- R6: Sub-mode code 1 (drop shadow): a non-glyph cell pixel whose upper-left neighbour was a visible glyph pixel outputs `SHADOW_CLR` and is active.
- R7: Sub-mode code 3 (outline): a non-glyph cell pixel outputs `SHADOW_CLR` and is active when any of its four already-received neighbours was a visible glyph pixel. These neighbours are:
  - left
  - upper-left
  - above
  - upper-right
- R8: With `frame_mode_in`=1 latched (frame mode), every accepted pixel that is neither a glyph nor a shadow outputs `pix_bg` and is active. This applies both outside cells and inside overlay cells.
- R9: `frame_mode_in` is sampled only in a `vsync_pulse` cycle, and `sub_mode_in` only in an `hsync_pulse` cycle. Changes at other times have no effect.
- R10: The blink phase is set by the number n of vsync pulses seen since reset.
  - For a character with `pix_blink_slow`=0, the off phase is when (n/16) is odd.
  - For a character with `pix_blink_slow`=1, the off phase is when (n/32) is odd.
  - Characters with `pix_blink`=0 never blink.
- R11: In the off phase, a blinking character shows no glyph and no shadow pixels; only its background rules apply. Its hidden glyph pixels also cast no shadow on later pixels.
- R12: Neighbour history is cleared at each vertical sync and at line boundaries. The first line of a frame has no upper neighbours, and the first pixel of a line has no left or upper-left neighbour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync_pulse | input | 1 | One-cycle pulse at the start of each frame |
| hsync_pulse | input | 1 | One-cycle pulse at the start of each line |
| frame_mode_in | input | 1 | Primary mode, 1 = frame mode, 0 = TV mode (sampled at vsync) |
| sub_mode_in | input | 2 | Line sub-mode: 0 overlay, 1 drop shadow, 2 panel, 3 outline (sampled at hsync) |
| pix_de | input | 1 | Pixel inside the active display area |
| pix_cell | input | 1 | Pixel inside a character cell |
| pix_glyph | input | 1 | Glyph bit of the pixel |
| pix_fg | input | 3 | Foreground colour of the character |
| pix_bg | input | 3 | Background colour of the character or word |
| pix_blink | input | 1 | Character blinks |
| pix_blink_slow | input | 1 | Blink period: 0 = 32 frames, 1 = 64 frames |
| osd_color | output | 3 | Colour code of the pixel |
| osd_active | output | 1 | OSD replaces the video for this pixel |

## Verification
Every pixel result is due one clock after the cycle in which the pixel was presented. The bench drives each cycle's inputs on the falling edge and compares both outputs on the next falling edge, so each comparison falls one rising edge after its stimulus. Sync pulses change the latched modes, the blink count and the neighbour history from the clock edge that samples them onward. The behavioural model therefore applies a pulse's effects only to pixels in later cycles. Mid-line mode changes, pixels driven before the first line sync, and long runs of frames that sweep both blink periods check that the latched values, not the live inputs, decide each result.

// File: rtl/osd_shade_pkg.sv
package osd_shade_pkg;

    typedef enum logic [1:0] {
        SUB_OVERLAY = 2'd0,
        SUB_DROP_NW = 2'd1,
        SUB_PANEL   = 2'd2,
        SUB_OUTLINE = 2'd3
    } sub_mode_e;

    typedef enum logic [1:0] {
        ST_NOFRAME = 2'd0,
        ST_VGAP    = 2'd1,
        ST_LINE    = 2'd2
    } raster_st_e;

    localparam int CLR_W = 3;

endpackage

// File: rtl/osd_blink_div.sv
module osd_blink_div #(
    parameter int FAST_DIV = 32,
    parameter int SLOW_DIV = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          vsync_pulse,
    output logic [$clog2(SLOW_DIV)-1:0]   cnt,
    output logic                          off_fast,
    output logic                          off_slow
);
    localparam int CW = $clog2(SLOW_DIV);
    localparam int FB = $clog2(FAST_DIV) - 1;

    // Field counter; the top bit of each divider range marks its off half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (vsync_pulse) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign off_fast = cnt[FB];
    assign off_slow = cnt[CW-1];

endmodule

// File: rtl/osd_row_hist.sv
module osd_row_hist #(
    parameter int LINE_W = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic next_line,
    input  logic wr_en,
    input  logic wr_bit,
    output logic nb_w,
    output logic nb_nw,
    output logic nb_n,
    output logic nb_ne
);
    localparam int XW = $clog2(LINE_W);
    localparam int PW = XW + 1;

    logic [LINE_W-1:0] cur_row, prev_row;
    logic [PW-1:0]     xpos;
    logic [XW-1:0]     xi, xm1, xp1;
    logic              in_rng;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_row  <= '0;
            prev_row <= '0;
            xpos     <= '0;
        end else if (clr) begin
            cur_row  <= '0;
            prev_row <= '0;
            xpos     <= '0;
        end else if (next_line) begin
            prev_row <= cur_row;
            cur_row  <= '0;
            xpos     <= '0;
        end else if (wr_en && in_rng) begin
            cur_row[xi] <= wr_bit;
            xpos        <= xpos + 1'b1;
        end
    end

    always_comb begin
        xi     = xpos[XW-1:0];
        xm1    = XW'(xpos - 1'b1);
        xp1    = XW'(xpos + 1'b1);
        in_rng = xpos < PW'(LINE_W);
        nb_w   = (xpos != '0) ? cur_row[xm1]  : 1'b0;
        nb_nw  = (xpos != '0) ? prev_row[xm1] : 1'b0;
        nb_n   = in_rng ? prev_row[xi] : 1'b0;
        nb_ne  = ((xpos + 1'b1) < PW'(LINE_W)) ? prev_row[xp1] : 1'b0;
    end

endmodule

// File: rtl/osd_shade_mixer.sv
module osd_shade_mixer
    import osd_shade_pkg::*;
#(
    parameter int         LINE_W     = 64,
    parameter int         FAST_DIV   = 32,
    parameter int         SLOW_DIV   = 64,
    parameter logic [2:0] SHADOW_CLR = 3'd0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vsync_pulse,
    input  logic       hsync_pulse,
    input  logic       frame_mode_in,
    input  logic [1:0] sub_mode_in,
    input  logic       pix_de,
    input  logic       pix_cell,
    input  logic       pix_glyph,
    input  logic [2:0] pix_fg,
    input  logic [2:0] pix_bg,
    input  logic       pix_blink,
    input  logic       pix_blink_slow,
    output logic [2:0] osd_color,
    output logic       osd_active
);
    localparam int BCW = $clog2(SLOW_DIV);

    raster_st_e      state, state_nx;
    sub_mode_e       sub_q;
    logic            frame_q;
    logic [BCW-1:0]  blink_cnt;
    logic            off_fast, off_slow;
    logic            nb_w, nb_nw, nb_n, nb_ne;
    logic            px_go, px_blank, px_vis, px_near, px_shade, px_fill;
    logic [2:0]      color_nx;
    logic            active_nx;

    osd_blink_div #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_blink (
        .clk        (clk),
        .rst_n      (rst_n),
        .vsync_pulse(vsync_pulse),
        .cnt        (blink_cnt),
        .off_fast   (off_fast),
        .off_slow   (off_slow)
    );

    osd_row_hist #(.LINE_W(LINE_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (vsync_pulse),
        .next_line(hsync_pulse),
        .wr_en    (px_go),
        .wr_bit   (px_vis),
        .nb_w     (nb_w),
        .nb_nw    (nb_nw),
        .nb_n     (nb_n),
        .nb_ne    (nb_ne)
    );

    // Raster state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_NOFRAME;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_NOFRAME: if (vsync_pulse) state_nx = ST_VGAP;
            ST_VGAP:    if (vsync_pulse) state_nx = ST_VGAP;
                        else if (hsync_pulse) state_nx = ST_LINE;
            ST_LINE:    if (vsync_pulse) state_nx = ST_VGAP;
            default:    state_nx = ST_NOFRAME;
        endcase
    end

    // Mode latches: primary mode per frame, sub-mode per line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= 1'b0;
            sub_q   <= SUB_OVERLAY;
        end else begin
            if (vsync_pulse) frame_q <= frame_mode_in;
            if (hsync_pulse) sub_q   <= sub_mode_e'(sub_mode_in);
        end
    end

    // Pixel classification
    always_comb begin
        px_go    = (state == ST_LINE) && pix_de && !vsync_pulse && !hsync_pulse;
        px_blank = pix_blink && (pix_blink_slow ? off_slow : off_fast);
        px_vis   = pix_cell && pix_glyph && !px_blank;
        unique case (sub_q)
            SUB_DROP_NW: px_near = nb_nw;
            SUB_OUTLINE: px_near = nb_w | nb_nw | nb_n | nb_ne;
            default:     px_near = 1'b0;
        endcase
        px_shade = pix_cell && !px_vis && !px_blank && px_near;
        px_fill  = frame_q || (pix_cell && (sub_q != SUB_OVERLAY));
    end

    // Output selection and register
    always_comb begin
        color_nx  = '0;
        active_nx = 1'b0;
        if (px_go) begin
            if (px_vis) begin
                color_nx  = pix_fg;
                active_nx = 1'b1;
            end else if (px_shade) begin
                color_nx  = SHADOW_CLR;
                active_nx = 1'b1;
            end else if (px_fill) begin
                color_nx  = pix_bg;
                active_nx = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osd_color  <= '0;
            osd_active <= 1'b0;
        end else begin
            osd_color  <= color_nx;
            osd_active <= active_nx;
        end
    end

endmodule

// File: rtl/osd_shade_checker.sv
module osd_shade_checker
    import osd_shade_pkg::*;
#(
    parameter int BCW = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           vsync_pulse,
    input logic           hsync_pulse,
    input logic           pix_de,
    input logic           pix_cell,
    input logic           pix_glyph,
    input logic [2:0]     pix_fg,
    input logic [2:0]     pix_bg,
    input logic [2:0]     osd_color,
    input logic           osd_active,
    input raster_st_e     state,
    input logic           frame_q,
    input sub_mode_e      sub_q,
    input logic           px_blank,
    input logic [BCW-1:0] blink_cnt
);
    logic take;
    assign take = (state == ST_LINE) && pix_de && !vsync_pulse && !hsync_pulse;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_de |=> (!osd_active && osd_color == 3'd0)); // R2
    AST_NOFRAME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NOFRAME) |=> !osd_active); // R2
    AST_GLYPH_FG: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pix_cell && pix_glyph && !px_blank) |=> (osd_active && osd_color == $past(pix_fg))); // R3
    AST_OVERLAY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pix_cell && !pix_glyph && sub_q == SUB_OVERLAY && !frame_q) |=> !osd_active); // R4
    AST_PANEL_BG: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pix_cell && !pix_glyph && sub_q == SUB_PANEL) |=> (osd_active && osd_color == $past(pix_bg))); // R5
    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_pulse |=> $stable(frame_q)); // R9
    AST_SUB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_pulse |=> $stable(sub_q)); // R9
    AST_BLINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_pulse |=> $stable(blink_cnt)); // R10
    AST_BLINK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_pulse |=> (blink_cnt == BCW'($past(blink_cnt) + 1'b1))); // R10

endmodule

bind osd_shade_mixer osd_shade_checker #(.BCW(BCW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vsync_pulse(vsync_pulse),
    .hsync_pulse(hsync_pulse),
    .pix_de     (pix_de),
    .pix_cell   (pix_cell),
    .pix_glyph  (pix_glyph),
    .pix_fg     (pix_fg),
    .pix_bg     (pix_bg),
    .osd_color  (osd_color),
    .osd_active (osd_active),
    .state      (state),
    .frame_q    (frame_q),
    .sub_q      (sub_q),
    .px_blank   (px_blank),
    .blink_cnt  (blink_cnt)
);

// File: tb/osd_shade_mixer_test.sv
`timescale 1ns/1ps
module osd_shade_mixer_test;
    localparam int LW     = 16;
    localparam int CELL   = 4;
    localparam int MAXY   = 6;
    localparam int FRAMES = 70;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vsync_pulse = 1'b0, hsync_pulse = 1'b0, frame_mode_in = 1'b0;
    logic [1:0] sub_mode_in = 2'd0;
    logic       pix_de = 1'b0, pix_cell = 1'b0, pix_glyph = 1'b0;
    logic [2:0] pix_fg = 3'd0, pix_bg = 3'd0;
    logic       pix_blink = 1'b0, pix_blink_slow = 1'b0;
    logic [2:0] osd_color;
    logic       osd_active;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // Behavioural model state
    bit        vmap [0:MAXY-1][0:LW-1];
    int        m_phase = 0, m_vs = 0, m_y = -1, m_x = 0;
    bit        m_frame = 1'b0;
    int        m_sub = 0;
    int        exp_c, exp_a;
    string     exp_tag;

    osd_shade_mixer #(.LINE_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .vsync_pulse(vsync_pulse), .hsync_pulse(hsync_pulse),
        .frame_mode_in(frame_mode_in), .sub_mode_in(sub_mode_in), .pix_de(pix_de),
        .pix_cell(pix_cell), .pix_glyph(pix_glyph), .pix_fg(pix_fg), .pix_bg(pix_bg),
        .pix_blink(pix_blink), .pix_blink_slow(pix_blink_slow),
        .osd_color(osd_color), .osd_active(osd_active)
    );

    always #2.5 clk = ~clk;

    function automatic bit seen(int y, int x);
        if (y < 0 || y >= MAXY || x < 0 || x >= LW) return 1'b0;
        return vmap[y][x];
    endfunction

    task automatic model_step();
        exp_c = 0; exp_a = 0; exp_tag = "R2";
        if (vsync_pulse) begin
            m_vs++; m_frame = frame_mode_in; m_phase = 1; m_y = -1;
            for (int y = 0; y < MAXY; y++)
                for (int x = 0; x < LW; x++) vmap[y][x] = 1'b0;
        end else if (hsync_pulse) begin
            m_sub = int'(sub_mode_in);
            if (m_phase != 0) begin m_phase = 2; m_y++; m_x = 0; end
        end else if (pix_de && m_phase == 2) begin
            bit blank, vis, near, shade, fill;
            blank = pix_blink && (((pix_blink_slow ? m_vs / 32 : m_vs / 16) % 2) == 1);
            vis   = pix_cell && pix_glyph && !blank;
            case (m_sub)
                1: near = seen(m_y - 1, m_x - 1);
                3: near = seen(m_y, m_x - 1) || seen(m_y - 1, m_x - 1) ||
                          seen(m_y - 1, m_x) || seen(m_y - 1, m_x + 1);
                default: near = 1'b0;
            endcase
            shade = pix_cell && !vis && !blank && near;
            fill  = m_frame || (pix_cell && m_sub != 0);
            if (vis) begin exp_c = int'(pix_fg); exp_a = 1; exp_tag = "R3"; end
            else if (shade) begin exp_c = 0; exp_a = 1; exp_tag = (m_sub == 1) ? "R6" : "R7"; end
            else if (fill) begin exp_c = int'(pix_bg); exp_a = 1; exp_tag = m_frame ? "R8" : "R5"; end
            else exp_tag = "R4";
            if (pix_blink) exp_tag = blank ? "R11" : "R10";
            if (!vis && (m_sub == 1 || m_sub == 3) && pix_cell && (m_y == 0 || m_x == 0)) exp_tag = "R12";
            if (int'(sub_mode_in) != m_sub) exp_tag = "R9";
            if (m_y < MAXY && m_x < LW) vmap[m_y][m_x] = vis;
            m_x++;
        end
    endtask

    // Inputs are set at a falling edge; the result is due after the next rising edge.
    task automatic cycle();
        model_step();
        @(negedge clk);
        checks++;
        if (int'(osd_color) != exp_c || int'(osd_active) != exp_a) begin
            errors++;
            $display("FAIL %s: color=%0d active=%0d expected color=%0d active=%0d",
                     exp_tag, osd_color, osd_active, exp_c, exp_a);
        end
    endtask

    task automatic quiet();
        pix_de = 1'b0; pix_cell = 1'b0; pix_glyph = 1'b0; pix_blink = 1'b0;
    endtask

    task automatic run_line(int f, int ln);
        hsync_pulse = 1'b1; sub_mode_in = 2'((f + ln) % 4);
        cycle();
        hsync_pulse = 1'b0;
        cycle();
        for (int c = 0; c < LW / CELL; c++) begin
            pix_cell       = (($urandom % 5) != 0);
            pix_fg         = 3'($urandom);
            pix_bg         = 3'($urandom);
            pix_blink      = (($urandom % 3) == 0);
            pix_blink_slow = 1'($urandom);
            for (int p = 0; p < CELL; p++) begin
                pix_de = 1'b1;
                pix_glyph = (($urandom % 3) == 0);
                if (($urandom % 4) == 0) sub_mode_in = 2'($urandom);
                cycle();
                if (($urandom % 5) == 0) begin
                    pix_de = 1'b0; cycle();
                end
            end
        end
        quiet();
        cycle();
    endtask

    task automatic run_frame(int f);
        vsync_pulse = 1'b1; frame_mode_in = ((f % 3) == 1);
        cycle();
        vsync_pulse = 1'b0; frame_mode_in = 1'($urandom);
        if ((f % 4) == 0) begin
            // Pixels before the first line sync are ignored (R2)
            pix_de = 1'b1; pix_cell = 1'b1; pix_glyph = 1'b1; pix_fg = 3'd7;
            cycle(); cycle();
            quiet();
        end
        cycle();
        for (int ln = 0; ln < 4; ln++) run_line(f, ln);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        checks++;
        if (osd_color != 3'd0 || osd_active != 1'b0) begin
            errors++;
            $display("FAIL R1: color=%0d active=%0d expected color=0 active=0", osd_color, osd_active);
        end
        rst_n = 1'b1;
        cycle();
        // R1/R2: line sync and pixels before any vertical sync produce nothing
        hsync_pulse = 1'b1; cycle(); hsync_pulse = 1'b0;
        pix_de = 1'b1; pix_cell = 1'b1; pix_glyph = 1'b1; pix_fg = 3'd5; pix_bg = 3'd2;
        repeat (5) cycle();
        quiet();
        cycle();
        for (int f = 0; f < FRAMES; f++) run_frame(f);
        repeat (3) cycle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: all requirements: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule